// File: doc/BRIEF.md
# Length-Steered Update Block Allocator

This block sits in a flash storage controller, in the path of host writes. Each write arrives as a starting logical sector address and a length in sectors, one per valid/ready handshake. The block works out which logical block the write falls in. A logical block is the span of one chain-block, meaning one erase block on every flash chip. The block then compares the request length with a programmable threshold and attaches an update resource to that logical block.

A short request counts as random traffic and gets a small DRAM buffer block from a shared pool. Any other request counts as sequential traffic and gets a whole NAND chain-block. A logical block can hold several DRAM blocks and one update chain-block at the same time. A per-logical-block mapping table records both kinds, and the table can be read through a query port.

When the pool a request needs is empty, the block raises a reclamation request for that pool kind and stops accepting writes. Other logic frees entries through the release ports and then pulses a done signal, after which the block tries the allocation again.

Top module: `rt_alloc_router`

## Requirements
- R1: A request whose length in sectors is less than THRESH (default 192) is granted a DRAM block, reported as gnt_kind = 0. A request of length THRESH or more is granted a chain-block, reported as gnt_kind = 1.
- R2: The logical block index is bits [LBLK_SHIFT +: LBLK_W] of req_addr, which is address >> 14 with the defaults. Address bits above that field have no effect, and the index is reported on gnt_lblk.
- R3: Both pools are bitmaps that are all free after reset, and each allocation takes the lowest-numbered free entry of its pool.
- R4: Every granted short request takes one new DRAM block (gnt_new = 1) and adds one to the DRAM block count of its logical block, so one logical block can hold several DRAM blocks.
- R5: A long request to a logical block that already has an update chain-block is granted that same chain-block id with gnt_new = 0 and takes nothing from the pool. Otherwise it takes a new chain-block with gnt_new = 1.
- R6: The mapping entry keeps the DRAM block count and the chain-block (attached flag and id) independently, so both kinds can coexist. qry_lblk returns the entry one clock later.
- R7: When the needed pool is empty, the block raises only the matching reclamation request (rcl_dram_req or rcl_chain_req), issues no grant, and holds req_rdy low until rcl_done.
- R8: On the clock after rcl_done is sampled, the block drops the reclamation request and retries. It grants in the following clock if the pool now has a free entry.
- R9: A DRAM release (id plus owning logical block) returns that id to the pool and subtracts one from the owner's count. A chain release names a logical block, frees its attached chain-block and clears the attachment, and does nothing if no chain-block is attached.
- R10: req_rdy falls on the clock that accepts a request. When no reclamation is needed, gnt_vld is a one-cycle pulse on the second clock after acceptance, and req_rdy rises again with it.
- R11: After reset, req_rdy is 1, gnt_vld and both reclamation requests are 0, and every mapping entry is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Write request valid |
| req_rdy | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Starting logical sector address |
| req_len | input | LEN_W | Request length in sectors |
| gnt_vld | output | 1 | Grant pulse |
| gnt_kind | output | 1 | 0 = DRAM block, 1 = chain-block |
| gnt_id | output | GID_W | Granted resource id |
| gnt_lblk | output | LBLK_W | Logical block of the grant |
| gnt_new | output | 1 | Resource newly taken from a pool |
| rcl_dram_req | output | 1 | DRAM pool reclamation needed |
| rcl_chain_req | output | 1 | Chain-block pool reclamation needed |
| rcl_done | input | 1 | Reclamation finished pulse |
| rel_dram_vld | input | 1 | Release a DRAM block |
| rel_dram_id | input | DID_W | DRAM block id being released |
| rel_dram_lblk | input | LBLK_W | Logical block that owned it |
| rel_chain_vld | input | 1 | Release the chain-block of a logical block |
| rel_chain_lblk | input | LBLK_W | Logical block whose chain-block is freed |
| qry_lblk | input | LBLK_W | Mapping entry to read |
| qry_dram_cnt | output | CNT_W | DRAM blocks attached to that entry |
| qry_chain_vld | output | 1 | Chain-block attached to that entry |
| qry_chain_id | output | CID_W | Id of the attached chain-block |

## Verification
The hardest case to reach is a stall followed by a retry, since it needs a pool drained to empty first. With only eight DRAM blocks and four chain-blocks, random short and long writes spread over a few logical blocks drain each pool within a handful of requests. On every stall the bench frees the lowest used entry, pulses done, and expects the grant exactly two clocks later. A directed sequence also puts both resource kinds on one logical block, hits the lengths and addresses on either side of each boundary, and releases a chain-block from a logical block that has none.

// File: rtl/rt_pkg.sv
package rt_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DECIDE, ST_WAIT} rt_state_e;
  localparam logic KIND_DRAM  = 1'b0;
  localparam logic KIND_CHAIN = 1'b1;
endpackage

// File: rtl/rt_classify.sv
module rt_classify #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LBLK_SHIFT = 14,
  parameter int LBLK_W     = 4,
  parameter int THRESH     = 192
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic [LBLK_W-1:0] lblk,
  output logic              is_short
);
  localparam logic [LEN_W-1:0] THR = LEN_W'(THRESH);

  assign lblk     = addr[LBLK_SHIFT +: LBLK_W];
  assign is_short = (len < THR);
endmodule

// File: rtl/rt_free_pool.sv
module rt_free_pool #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc,
  input  logic          rel_vld,
  input  logic [IW-1:0] rel_id,
  output logic          empty,
  output logic [IW-1:0] pick_id
);
  logic [N-1:0] free_q;
  logic [N-1:0] rel_mask, alloc_mask;

  always_comb begin
    pick_id = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_q[i]) pick_id = IW'(i);
    end
  end

  assign empty      = ~|free_q;
  assign rel_mask   = rel_vld ? (N'(1) << rel_id) : '0;
  assign alloc_mask = alloc   ? (N'(1) << pick_id) : '0;

  always_ff @(posedge clk) begin
    if (rst) free_q <= '1;
    else     free_q <= (free_q | rel_mask) & ~alloc_mask;
  end

  AST_ALLOC_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    alloc |-> !empty); // R3
  AST_REL_WAS_USED: assert property (@(posedge clk) disable iff (rst)
    rel_vld |-> !free_q[rel_id]); // R9
endmodule

// File: rtl/rt_map_table.sv
module rt_map_table #(
  parameter int LBLK_W = 4,
  parameter int CNT_W  = 4,
  parameter int CID_W  = 2,
  parameter int MAXC   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc_vld,
  input  logic [LBLK_W-1:0] inc_lblk,
  input  logic              dec_vld,
  input  logic [LBLK_W-1:0] dec_lblk,
  input  logic              set_vld,
  input  logic [LBLK_W-1:0] set_lblk,
  input  logic [CID_W-1:0]  set_id,
  input  logic              clr_vld,
  input  logic [LBLK_W-1:0] clr_lblk,
  input  logic [LBLK_W-1:0] rd_lblk,
  output logic              rd_chv,
  output logic [CID_W-1:0]  rd_chid,
  output logic              clr_chv,
  output logic [CID_W-1:0]  clr_chid,
  input  logic [LBLK_W-1:0] q_lblk,
  output logic [CNT_W-1:0]  q_cnt,
  output logic              q_chv,
  output logic [CID_W-1:0]  q_chid
);
  localparam int NL = 1 << LBLK_W;

  logic [CNT_W-1:0] cnt_q  [NL];
  logic             chv_q  [NL];
  logic [CID_W-1:0] chid_q [NL];

  assign rd_chv   = chv_q[rd_lblk];
  assign rd_chid  = chid_q[rd_lblk];
  assign clr_chv  = chv_q[clr_lblk];
  assign clr_chid = chid_q[clr_lblk];

  for (genvar g = 0; g < NL; g++) begin : g_ent
    logic up, dn;
    assign up = inc_vld && (inc_lblk == LBLK_W'(g));
    assign dn = dec_vld && (dec_lblk == LBLK_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q[g]  <= '0;
        chv_q[g]  <= 1'b0;
        chid_q[g] <= '0;
      end else begin
        if (up && !dn)                          cnt_q[g] <= cnt_q[g] + 1'b1;
        else if (dn && !up && cnt_q[g] != '0)   cnt_q[g] <= cnt_q[g] - 1'b1;
        if (set_vld && set_lblk == LBLK_W'(g)) begin
          chv_q[g]  <= 1'b1;
          chid_q[g] <= set_id;
        end else if (clr_vld && clr_lblk == LBLK_W'(g)) begin
          chv_q[g]  <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_cnt  <= '0;
      q_chv  <= 1'b0;
      q_chid <= '0;
    end else begin
      q_cnt  <= cnt_q[q_lblk];
      q_chv  <= chv_q[q_lblk];
      q_chid <= chid_q[q_lblk];
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    inc_vld |-> (cnt_q[inc_lblk] < CNT_W'(MAXC))); // R4
  AST_SET_UNATTACHED: assert property (@(posedge clk) disable iff (rst)
    set_vld |-> !chv_q[set_lblk]); // R5
endmodule

// File: rtl/rt_alloc_router.sv
module rt_alloc_router #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LBLK_SHIFT = 14,
  parameter int LBLK_W     = 4,
  parameter int THRESH     = 192,
  parameter int DRAM_BLKS  = 8,
  parameter int CHAIN_BLKS = 4,
  localparam int DID_W = (DRAM_BLKS > 1) ? $clog2(DRAM_BLKS) : 1,
  localparam int CID_W = (CHAIN_BLKS > 1) ? $clog2(CHAIN_BLKS) : 1,
  localparam int CNT_W = $clog2(DRAM_BLKS + 1),
  localparam int GID_W = (DID_W > CID_W) ? DID_W : CID_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_vld,
  output logic              req_rdy,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              gnt_vld,
  output logic              gnt_kind,
  output logic [GID_W-1:0]  gnt_id,
  output logic [LBLK_W-1:0] gnt_lblk,
  output logic              gnt_new,
  output logic              rcl_dram_req,
  output logic              rcl_chain_req,
  input  logic              rcl_done,
  input  logic              rel_dram_vld,
  input  logic [DID_W-1:0]  rel_dram_id,
  input  logic [LBLK_W-1:0] rel_dram_lblk,
  input  logic              rel_chain_vld,
  input  logic [LBLK_W-1:0] rel_chain_lblk,
  input  logic [LBLK_W-1:0] qry_lblk,
  output logic [CNT_W-1:0]  qry_dram_cnt,
  output logic              qry_chain_vld,
  output logic [CID_W-1:0]  qry_chain_id
);
  import rt_pkg::*;

  rt_state_e         state_q;
  logic [LBLK_W-1:0] lblk_q, in_lblk;
  logic              short_q, in_short;
  logic              d_empty, c_empty;
  logic [DID_W-1:0]  d_pick;
  logic [CID_W-1:0]  c_pick, rd_chid, clr_chid;
  logic              rd_chv, clr_chv;
  logic              decide, d_alloc, c_alloc, c_reuse, c_rel;

  rt_classify #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LBLK_SHIFT(LBLK_SHIFT),
                .LBLK_W(LBLK_W), .THRESH(THRESH)) u_cls (
    .addr(req_addr), .len(req_len), .lblk(in_lblk), .is_short(in_short));

  assign req_rdy = (state_q == ST_IDLE);
  assign decide  = (state_q == ST_DECIDE);
  assign d_alloc = decide && short_q && !d_empty;
  assign c_reuse = decide && !short_q && rd_chv;
  assign c_alloc = decide && !short_q && !rd_chv && !c_empty;
  assign c_rel   = rel_chain_vld && clr_chv;

  rt_free_pool #(.N(DRAM_BLKS), .IW(DID_W)) u_dpool (
    .clk(clk), .rst(rst), .alloc(d_alloc), .rel_vld(rel_dram_vld),
    .rel_id(rel_dram_id), .empty(d_empty), .pick_id(d_pick));

  rt_free_pool #(.N(CHAIN_BLKS), .IW(CID_W)) u_cpool (
    .clk(clk), .rst(rst), .alloc(c_alloc), .rel_vld(c_rel),
    .rel_id(clr_chid), .empty(c_empty), .pick_id(c_pick));

  rt_map_table #(.LBLK_W(LBLK_W), .CNT_W(CNT_W), .CID_W(CID_W),
                 .MAXC(DRAM_BLKS)) u_map (
    .clk(clk), .rst(rst),
    .inc_vld(d_alloc), .inc_lblk(lblk_q),
    .dec_vld(rel_dram_vld), .dec_lblk(rel_dram_lblk),
    .set_vld(c_alloc), .set_lblk(lblk_q), .set_id(c_pick),
    .clr_vld(c_rel), .clr_lblk(rel_chain_lblk),
    .rd_lblk(lblk_q), .rd_chv(rd_chv), .rd_chid(rd_chid),
    .clr_chv(clr_chv), .clr_chid(clr_chid),
    .q_lblk(qry_lblk), .q_cnt(qry_dram_cnt), .q_chv(qry_chain_vld),
    .q_chid(qry_chain_id));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      lblk_q        <= '0;
      short_q       <= 1'b0;
      gnt_vld       <= 1'b0;
      gnt_kind      <= KIND_DRAM;
      gnt_id        <= '0;
      gnt_lblk      <= '0;
      gnt_new       <= 1'b0;
      rcl_dram_req  <= 1'b0;
      rcl_chain_req <= 1'b0;
    end else begin
      gnt_vld <= d_alloc || c_alloc || c_reuse;
      if (d_alloc || c_alloc || c_reuse) begin
        gnt_kind <= short_q ? KIND_DRAM : KIND_CHAIN;
        gnt_id   <= d_alloc ? GID_W'(d_pick) : (c_alloc ? GID_W'(c_pick) : GID_W'(rd_chid));
        gnt_lblk <= lblk_q;
        gnt_new  <= !c_reuse;
      end
      unique case (state_q)
        ST_IDLE: if (req_vld) begin
          state_q <= ST_DECIDE;
          lblk_q  <= in_lblk;
          short_q <= in_short;
        end
        ST_DECIDE: begin
          if (short_q && d_empty) begin
            state_q      <= ST_WAIT;
            rcl_dram_req <= 1'b1;
          end else if (!short_q && !rd_chv && c_empty) begin
            state_q       <= ST_WAIT;
            rcl_chain_req <= 1'b1;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_WAIT: if (rcl_done) begin
          state_q       <= ST_DECIDE;
          rcl_dram_req  <= 1'b0;
          rcl_chain_req <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_GNT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    gnt_vld |=> !gnt_vld); // R10
  AST_RCL_STALLS: assert property (@(posedge clk) disable iff (rst)
    (rcl_dram_req || rcl_chain_req) |-> !req_rdy); // R7
  AST_RCL_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rcl_dram_req, rcl_chain_req})); // R7
  AST_RETRY_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(rcl_dram_req) |=> (gnt_vld || rcl_dram_req)); // R8
  AST_DRAM_ALWAYS_NEW: assert property (@(posedge clk) disable iff (rst)
    (gnt_vld && gnt_kind == KIND_DRAM) |-> gnt_new); // R4
endmodule

// File: tb/tb_rt_alloc_router.sv
module tb_rt_alloc_router;
  localparam int NDB = 8, NCB = 4, NL = 16, THR = 192;

  logic        clk = 0, rst = 1;
  logic        req_vld = 0, req_rdy;
  logic [31:0] req_addr = 0;
  logic [15:0] req_len = 0;
  logic        gnt_vld, gnt_kind, gnt_new;
  logic [2:0]  gnt_id;
  logic [3:0]  gnt_lblk;
  logic        rcl_dram_req, rcl_chain_req, rcl_done = 0;
  logic        rel_dram_vld = 0, rel_chain_vld = 0;
  logic [2:0]  rel_dram_id = 0;
  logic [3:0]  rel_dram_lblk = 0, rel_chain_lblk = 0, qry_lblk = 0;
  logic [3:0]  qry_dram_cnt;
  logic        qry_chain_vld;
  logic [1:0]  qry_chain_id;

  int n_chk = 0, n_bad = 0;
  int d_free[NDB], d_own[NDB], c_free[NCB], c_own[NCB];
  int m_cnt[NL], m_chv[NL], m_chid[NL];

  always #2 clk = ~clk;

  rt_alloc_router dut (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int low_free_d();
    for (int i = NDB - 1, r = -1; i >= -1; i--) begin
      if (i < 0) return r;
      if (d_free[i] != 0) r = i;
    end
    return -1;
  endfunction

  function automatic int low_free_c();
    int r = -1;
    for (int i = NCB - 1; i >= 0; i--) if (c_free[i] != 0) r = i;
    return r;
  endfunction

  task automatic query(input int lb);
    @(negedge clk); qry_lblk = 4'(lb);
    @(negedge clk);
    check("R6 dram count", int'(qry_dram_cnt), m_cnt[lb]);
    check("R6 chain attached", int'(qry_chain_vld), m_chv[lb]);
    if (m_chv[lb] != 0) check("R6 chain id", int'(qry_chain_id), m_chid[lb]);
  endtask

  task automatic release_dram(input int id);
    rel_dram_vld = 1; rel_dram_id = 3'(id); rel_dram_lblk = 4'(d_own[id]);
    @(negedge clk); rel_dram_vld = 0;
    d_free[id] = 1; m_cnt[d_own[id]]--;
  endtask

  task automatic release_chain(input int lb);
    rel_chain_vld = 1; rel_chain_lblk = 4'(lb);
    @(negedge clk); rel_chain_vld = 0;
    if (m_chv[lb] != 0) begin c_free[m_chid[lb]] = 1; m_chv[lb] = 0; end
  endtask

  task automatic do_write(input logic [31:0] a, input int len);
    int lb, sh, eid, enew, stalled, it;
    lb = int'(a[17:14]); sh = (len < THR) ? 1 : 0; stalled = 0;
    @(negedge clk); req_vld = 1; req_addr = a; req_len = 16'(len);
    while (!req_rdy) @(negedge clk);
    @(negedge clk); req_vld = 0;
    check("R10 ready low after accept", int'(req_rdy), 0);
    for (it = 0; it < 20; it++) begin
      @(negedge clk);
      if (gnt_vld) break;
      if (stalled == 2) check("R8 grant after retry", int'(gnt_vld), 1);
      if (rcl_dram_req || rcl_chain_req) begin
        check("R7 reclaim kind", int'(rcl_dram_req), sh);
        check("R7 pool empty", sh ? low_free_d() : low_free_c(), -1);
        check("R7 ready held low", int'(req_rdy), 0);
        if (rcl_dram_req) release_dram(0);
        else release_chain(c_own[0]);
        check("R7 reclaim held", int'(rcl_dram_req || rcl_chain_req), 1);
        rcl_done = 1;
        @(negedge clk); rcl_done = 0;
        check("R8 reclaim dropped", int'(rcl_dram_req || rcl_chain_req), 0);
        check("R8 no early grant", int'(gnt_vld), 0);
        stalled = 2;
      end else if (it == 0 && stalled == 0) begin
        check("R10 grant on second clock", int'(gnt_vld), 1);
      end
    end
    check("R10 grant seen", int'(gnt_vld), 1);
    if (sh != 0) begin
      eid = low_free_d(); enew = 1;
      d_free[eid] = 0; d_own[eid] = lb; m_cnt[lb]++;
    end else if (m_chv[lb] != 0) begin
      eid = m_chid[lb]; enew = 0;
    end else begin
      eid = low_free_c(); enew = 1;
      c_free[eid] = 0; c_own[eid] = lb; m_chv[lb] = 1; m_chid[lb] = eid;
    end
    check("R1 kind", int'(gnt_kind), sh ? 0 : 1);
    check("R2 lblk", int'(gnt_lblk), lb);
    check("R3 id lowest free", int'(gnt_id), eid);
    check(sh ? "R4 new dram" : "R5 new flag", int'(gnt_new), enew);
    @(negedge clk);
    check("R10 single pulse and ready", int'(gnt_vld) * 2 + int'(req_rdy), 1);
    query(lb);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NDB; i++) begin d_free[i] = 1; d_own[i] = 0; end
    for (int i = 0; i < NCB; i++) begin c_free[i] = 1; c_own[i] = 0; end
    for (int i = 0; i < NL; i++) begin m_cnt[i] = 0; m_chv[i] = 0; m_chid[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R11 ready", int'(req_rdy), 1);
    check("R11 no grant", int'(gnt_vld), 0);
    check("R11 no reclaim", int'(rcl_dram_req || rcl_chain_req), 0);
    query(5);
    // R1 threshold edges, R2 address edges and ignored upper bits
    do_write(32'd16383, THR - 1);
    do_write(32'd16384, THR);
    do_write(32'h0010_4000, 0);
    // R6 both kinds on one logical block, R4 several DRAM blocks
    do_write(32'd3 << 14, 8);
    do_write(32'd3 << 14, 4096);
    do_write(32'd3 << 14, 16);
    // R5 reuse of an attached chain-block
    do_write(32'd3 << 14, 300);
    // R9 chain release on a block without one is ignored
    release_chain(7);
    query(7);
    do_write(32'd7 << 14, 500);
    // R9 DRAM release in idle returns id 1 as lowest free
    release_dram(1);
    query(3);
    do_write(32'd9 << 14, 1);
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      int l, pick;
      a = {$urandom} & 32'h00FF_FFFF;
      a[17:14] = 4'($urandom_range(0, 5));
      pick = $urandom_range(0, 3);
      l = (pick == 0) ? $urandom_range(0, THR - 1) :
          (pick == 1) ? $urandom_range(THR, 4000) :
          (pick == 2) ? THR - 1 + $urandom_range(0, 1) : $urandom_range(1, 64);
      do_write(a, l);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule